// File: doc/BRIEF.md
# Multi-channel event builder and drain

This block gathers finished events from ten channels and hands them to an external FIFO. Every channel has two queues of its own: one holds event headers, each header stating how many samples belong to it, and the other holds the samples themselves. A round-robin arbiter picks one channel that has a header waiting. That channel keeps the grant until its whole packet has been written into a single accepted-event FIFO shared by all channels. The packet is a descriptor word, then the header, then the samples.

A drain state machine empties the shared FIFO. It looks at each packet's descriptor and compares the packet length with the free space the external FIFO reports. The packet is then either written in full or read out and discarded in full. A saturating counter records every discarded packet.

Channels that are waiting for the grant simply hold their data. Nothing is lost at this block's input; only the external side can cause an event to be dropped.

Top module: `evb_event_merger`

## Requirements
- R1: Each packet is a descriptor word, then the header word, then the header's samples in queue order. In the descriptor, bits [LEN_W-1:0] hold the total word count (sample count + 2), bits [LEN_W+CH_W-1:LEN_W] hold the channel index, and all higher bits are zero. Packets with zero samples are allowed.
- R2: The grant is round-robin. After reset the search starts at channel 0. After a packet completes, the search starts at the channel above the one just served, wrapping from N_CH-1 to 0.
- R3: A granted channel keeps the grant until its last word is written, so packets never interleave. At most one header or sample pop occurs per cycle across all channels.
- R4: If a granted channel's sample queue runs empty mid-packet, the builder waits without popping and loses no data. Every other channel waits as well.
- R5: The shared FIFO is never written when full and never read when empty.
- R6: When a descriptor reaches the head of the shared FIFO, the packet is written whole to the external port if ext_free is at least the packet length. Otherwise every word of the packet is consumed with no external write.
- R7: Each discarded packet raises drop_count by exactly one, visible on the cycle after the descriptor is consumed.
- R8: drop_count saturates at its all-ones value.
- R9: drop_clr zeroes drop_count on the next cycle and takes priority over an increment in the same cycle.
- R10: During and right after reset, there are no pops, ext_wr is low and drop_count is zero.
- R11: ext_wr is raised only while a packet that fits is being sent, one word per cycle as words become available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_hdr_valid | input | N_CH | Header queue of channel c is non-empty |
| ch_hdr_word | input | N_CH*DATA_W | Head header word, channel c at slice c |
| ch_hdr_nsamp | input | N_CH*LEN_W | Sample count belonging to the head header |
| ch_hdr_pop | output | N_CH | Pop the head header of channel c |
| ch_smp_valid | input | N_CH | Sample queue of channel c is non-empty |
| ch_smp_word | input | N_CH*DATA_W | Head sample word, channel c at slice c |
| ch_smp_pop | output | N_CH | Pop the head sample of channel c |
| ext_free | input | FREE_W | Free word count of the external FIFO |
| ext_wr | output | 1 | Write strobe to the external FIFO |
| ext_word | output | DATA_W | Word written to the external FIFO |
| drop_clr | input | 1 | Synchronous clear of the drop counter |
| drop_count | output | DROP_W | Count of discarded packets |

## Verification
Assertions check the following on every cycle:
- At most one channel pop occurs per cycle, and no pop happens on an empty queue.
- The shared FIFO never overflows or underflows.
- The drain never writes while it discards.
- The counter moves by at most one, saturates and obeys the clear.

The bench's scenarios are the only way to show the rest:
- the round-robin order and the packet contents;
- that a stalled channel blocks the others without losing words;
- the exact fit boundary between sending and dropping;
- the drop count over whole runs, including saturation on a narrow-counter instance.

// File: rtl/evb_pkg.sv
package evb_pkg;
    typedef enum logic [1:0] {PK_IDLE, PK_DESC, PK_HEAD, PK_BODY} pk_state_e;
    typedef enum logic [1:0] {DR_IDLE, DR_SEND, DR_DROP} dr_state_e;

    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/evb_rr_pick.sv
module evb_rr_pick #(
    parameter int N_CH = 10,
    localparam int CH_W = evb_pkg::idx_bits(N_CH)
) (
    input  logic [N_CH-1:0] req,
    input  logic [CH_W-1:0] start,
    output logic            found,
    output logic [CH_W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N_CH; i++) begin
            int cand;
            cand = int'(start) + i;
            if (cand >= N_CH) cand = cand - N_CH;
            if (!found && req[CH_W'(cand)]) begin
                found = 1'b1;
                pick  = CH_W'(cand);
            end
        end
    end
endmodule

// File: rtl/evb_fifo.sv
module evb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = evb_pkg::idx_bits(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [AW:0]   count;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [W-1:0] mem [DEPTH];

    assign full      = (r_q.count == (AW+1)'(DEPTH));
    assign not_empty = (r_q.count != '0);
    assign rd_data   = mem[r_q.rd_ptr];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.wr_ptr = (r_q.wr_ptr == AW'(DEPTH-1)) ? '0 : r_q.wr_ptr + AW'(1);
        end
        if (rd_en) begin
            r_d.rd_ptr = (r_q.rd_ptr == AW'(DEPTH-1)) ? '0 : r_q.rd_ptr + AW'(1);
        end
        case ({wr_en, rd_en})
            2'b10:   r_d.count = r_q.count + (AW+1)'(1);
            2'b01:   r_d.count = r_q.count - (AW+1)'(1);
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[r_q.wr_ptr] <= wr_data;
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> !rd_en);
endmodule

// File: rtl/evb_packer.sv
module evb_packer #(
    parameter int N_CH   = 10,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    localparam int CH_W  = evb_pkg::idx_bits(N_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        hdr_valid,
    input  logic [N_CH*DATA_W-1:0] hdr_data,
    input  logic [N_CH*LEN_W-1:0]  hdr_len,
    output logic [N_CH-1:0]        hdr_pop,
    input  logic [N_CH-1:0]        smp_valid,
    input  logic [N_CH*DATA_W-1:0] smp_data,
    output logic [N_CH-1:0]        smp_pop,
    input  logic                   out_full,
    output logic                   out_wr,
    output logic [DATA_W-1:0]      out_data
);
    import evb_pkg::*;

    localparam int PAD_W = DATA_W - CH_W - LEN_W;

    typedef struct packed {
        pk_state_e       state;
        logic [CH_W-1:0] grant;
        logic [CH_W-1:0] next_ptr;
        logic [LEN_W-1:0] left;
    } pk_regs_t;

    pk_regs_t r_q, r_d;

    logic              found;
    logic [CH_W-1:0]   pick;
    logic [DATA_W-1:0] sel_hdr, sel_smp, desc_word;
    logic [LEN_W-1:0]  sel_len, pkt_words;
    logic [CH_W-1:0]   after_grant;

    evb_rr_pick #(.N_CH(N_CH)) u_pick (
        .req   (hdr_valid),
        .start (r_q.next_ptr),
        .found (found),
        .pick  (pick)
    );

    assign sel_hdr     = hdr_data[int'(r_q.grant)*DATA_W +: DATA_W];
    assign sel_smp     = smp_data[int'(r_q.grant)*DATA_W +: DATA_W];
    assign sel_len     = hdr_len[int'(r_q.grant)*LEN_W +: LEN_W];
    assign pkt_words   = sel_len + LEN_W'(2);
    assign desc_word   = {{PAD_W{1'b0}}, r_q.grant, pkt_words};
    assign after_grant = (r_q.grant == CH_W'(N_CH-1)) ? '0 : r_q.grant + CH_W'(1);

    always_comb begin
        r_d      = r_q;
        hdr_pop  = '0;
        smp_pop  = '0;
        out_wr   = 1'b0;
        out_data = '0;
        case (r_q.state)
            PK_IDLE: begin
                if (found) begin
                    r_d.grant = pick;
                    r_d.state = PK_DESC;
                end
            end
            PK_DESC: begin
                if (!out_full) begin
                    out_wr    = 1'b1;
                    out_data  = desc_word;
                    r_d.state = PK_HEAD;
                end
            end
            PK_HEAD: begin
                if (!out_full) begin
                    out_wr              = 1'b1;
                    out_data            = sel_hdr;
                    hdr_pop[r_q.grant]  = 1'b1;
                    r_d.left            = sel_len;
                    if (sel_len == '0) begin
                        r_d.state    = PK_IDLE;
                        r_d.next_ptr = after_grant;
                    end else begin
                        r_d.state = PK_BODY;
                    end
                end
            end
            PK_BODY: begin
                if (!out_full && smp_valid[r_q.grant]) begin
                    out_wr              = 1'b1;
                    out_data            = sel_smp;
                    smp_pop[r_q.grant]  = 1'b1;
                    r_d.left            = r_q.left - LEN_W'(1);
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.state    = PK_IDLE;
                        r_d.next_ptr = after_grant;
                    end
                end
            end
            default: r_d.state = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= PK_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_pop, smp_pop}));
    assert_pop_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((hdr_pop & ~hdr_valid) == '0) && ((smp_pop & ~smp_valid) == '0));
endmodule

// File: rtl/evb_drain.sv
module evb_drain #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int FREE_W = 16,
    parameter int DROP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_pop,
    input  logic [FREE_W-1:0] ext_free,
    output logic              ext_wr,
    output logic [DATA_W-1:0] ext_data,
    input  logic              drop_clr,
    output logic [DROP_W-1:0] drop_count
);
    import evb_pkg::*;

    localparam int CMP_W = FREE_W + LEN_W;

    typedef struct packed {
        dr_state_e         state;
        logic [LEN_W-1:0]  left;
        logic [DROP_W-1:0] drops;
    } dr_regs_t;

    dr_regs_t r_q, r_d;

    logic [LEN_W-1:0] head_len;
    logic [CMP_W-1:0] room_ext, need_ext;
    logic             fits, bump;

    assign head_len = in_data[LEN_W-1:0];
    assign room_ext = {{LEN_W{1'b0}}, ext_free};
    assign need_ext = {{FREE_W{1'b0}}, head_len};
    assign fits     = (room_ext >= need_ext);

    always_comb begin
        r_d      = r_q;
        in_pop   = 1'b0;
        ext_wr   = 1'b0;
        ext_data = in_data;
        bump     = 1'b0;
        case (r_q.state)
            DR_IDLE: begin
                if (in_valid) begin
                    in_pop   = 1'b1;
                    r_d.left = head_len - LEN_W'(1);
                    if (fits) begin
                        ext_wr    = 1'b1;
                        r_d.state = DR_SEND;
                    end else begin
                        bump      = 1'b1;
                        r_d.state = DR_DROP;
                    end
                end
            end
            DR_SEND, DR_DROP: begin
                if (in_valid) begin
                    in_pop   = 1'b1;
                    ext_wr   = (r_q.state == DR_SEND);
                    r_d.left = r_q.left - LEN_W'(1);
                    if (r_q.left == LEN_W'(1)) r_d.state = DR_IDLE;
                end
            end
            default: r_d.state = DR_IDLE;
        endcase
        if (drop_clr) begin
            r_d.drops = '0;
        end else if (bump && (r_q.drops != '1)) begin
            r_d.drops = r_q.drops + DROP_W'(1);
        end
    end

    assign drop_count = r_q.drops;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= DR_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assert_silent_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DR_DROP) |-> !ext_wr);
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_clr |=> (drop_count == $past(drop_count)) ||
                      (drop_count == $past(drop_count) + DROP_W'(1)));
    assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((drop_count == '1) && !drop_clr) |=> (drop_count == '1));
    assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_clr |=> (drop_count == '0));
endmodule

// File: rtl/evb_event_merger.sv
module evb_event_merger #(
    parameter int N_CH       = 10,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int FIFO_DEPTH = 32,
    parameter int FREE_W     = 16,
    parameter int DROP_W     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        ch_hdr_valid,
    input  logic [N_CH*DATA_W-1:0] ch_hdr_word,
    input  logic [N_CH*LEN_W-1:0]  ch_hdr_nsamp,
    output logic [N_CH-1:0]        ch_hdr_pop,
    input  logic [N_CH-1:0]        ch_smp_valid,
    input  logic [N_CH*DATA_W-1:0] ch_smp_word,
    output logic [N_CH-1:0]        ch_smp_pop,
    input  logic [FREE_W-1:0]      ext_free,
    output logic                   ext_wr,
    output logic [DATA_W-1:0]      ext_word,
    input  logic                   drop_clr,
    output logic [DROP_W-1:0]      drop_count
);
    logic              sh_wr, sh_full, sh_rd, sh_nonempty;
    logic [DATA_W-1:0] sh_wdata, sh_rdata;

    evb_packer #(.N_CH(N_CH), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (ch_hdr_valid),
        .hdr_data  (ch_hdr_word),
        .hdr_len   (ch_hdr_nsamp),
        .hdr_pop   (ch_hdr_pop),
        .smp_valid (ch_smp_valid),
        .smp_data  (ch_smp_word),
        .smp_pop   (ch_smp_pop),
        .out_full  (sh_full),
        .out_wr    (sh_wr),
        .out_data  (sh_wdata)
    );

    evb_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_shared (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sh_wr),
        .wr_data   (sh_wdata),
        .full      (sh_full),
        .rd_en     (sh_rd),
        .rd_data   (sh_rdata),
        .not_empty (sh_nonempty)
    );

    evb_drain #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FREE_W(FREE_W), .DROP_W(DROP_W)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (sh_nonempty),
        .in_data    (sh_rdata),
        .in_pop     (sh_rd),
        .ext_free   (ext_free),
        .ext_wr     (ext_wr),
        .ext_data   (ext_word),
        .drop_clr   (drop_clr),
        .drop_count (drop_count)
    );
endmodule

// File: tb/evb_event_merger_tb.sv
`timescale 1ns/1ps
module evb_event_merger_tb_top;
    localparam int N  = 10;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int FW = 16;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    hv, hp, sv, sp;
    logic [N*DW-1:0] hd, sd;
    logic [N*LW-1:0] hl;
    logic [FW-1:0]   ext_free;
    logic            ext_wr, drop_clr;
    logic [DW-1:0]   ext_word;
    logic [31:0]     drop_count;
    logic [N-1:0]    hp2, sp2;
    logic            ext_wr2;
    logic [DW-1:0]   ew2;
    logic [1:0]      dc2;

    evb_event_merger dut_i (
        .clk(clk), .rst_n(rst_n), .ch_hdr_valid(hv), .ch_hdr_word(hd), .ch_hdr_nsamp(hl),
        .ch_hdr_pop(hp), .ch_smp_valid(sv), .ch_smp_word(sd), .ch_smp_pop(sp),
        .ext_free(ext_free), .ext_wr(ext_wr), .ext_word(ext_word),
        .drop_clr(drop_clr), .drop_count(drop_count));

    evb_event_merger #(.DROP_W(2)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .ch_hdr_valid(hv), .ch_hdr_word(hd), .ch_hdr_nsamp(hl),
        .ch_hdr_pop(hp2), .ch_smp_valid(sv), .ch_smp_word(sd), .ch_smp_pop(sp2),
        .ext_free(ext_free), .ext_wr(ext_wr2), .ext_word(ew2),
        .drop_clr(drop_clr), .drop_count(dc2));

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // channel queues (what the channel FIFOs hold) and expected output
    logic [DW-1:0] hq_d [N][$];
    int            hq_l [N][$];
    logic [DW-1:0] sq   [N][$];
    logic [DW-1:0] eq   [N][$];
    int            el   [N][$];
    int            order_q[$];
    bit            order_on = 1'b0;
    int            seq = 0;
    logic [N-1:0]  hp_s = '0, sp_s = '0;

    function automatic logic [DW-1:0] smp_val(int c, int id, int k);
        return {8'h5A, 8'(c), 8'(id), 8'(k)};
    endfunction

    // channel FIFO model: apply pops sampled before the edge, then drive new heads
    initial begin
        hv = '0; sv = '0; hd = '0; sd = '0; hl = '0;
        forever begin
            @(posedge clk);
            #1;
            for (int c = 0; c < N; c++) begin
                if (hp_s[c]) begin
                    if (hq_d[c].size() == 0) chk(1'b0, "R4 header pop on empty queue", 64'(c), 0);
                    else begin
                        void'(hq_d[c].pop_front());
                        void'(hq_l[c].pop_front());
                    end
                end
                if (sp_s[c]) begin
                    if (sq[c].size() == 0) chk(1'b0, "R4 sample pop on empty queue", 64'(c), 0);
                    else void'(sq[c].pop_front());
                end
            end
            hp_s = '0;
            sp_s = '0;
            for (int c = 0; c < N; c++) begin
                hv[c]              = (hq_d[c].size() > 0);
                hd[c*DW +: DW]     = hv[c] ? hq_d[c][0] : '0;
                hl[c*LW +: LW]     = hv[c] ? LW'(hq_l[c][0]) : '0;
                sv[c]              = (sq[c].size() > 0);
                sd[c*DW +: DW]     = sv[c] ? sq[c][0] : '0;
            end
        end
    end

    // reference check of the external write stream, every clock
    int cur_ch = -1;
    int cur_left = 0;
    bit junk = 1'b0;
    always @(negedge clk) begin
        hp_s = hp;
        sp_s = sp;
        if (rst_n && ext_wr) begin
            if (cur_ch < 0) begin
                int ch;
                int len;
                ch  = int'(ext_word[LW +: CW]);
                len = int'(ext_word[LW-1:0]);
                chk(ext_word[DW-1:LW+CW] == '0, "R1 descriptor spare bits zero", 64'(ext_word), 0);
                cur_left = len - 1;
                if (ch >= N || el[ch].size() == 0) begin
                    chk(1'b0, "R6 packet sent that should not be", 64'(ch), 0);
                    junk   = 1'b1;
                    cur_ch = 0;
                end else begin
                    junk = 1'b0;
                    chk(len == el[ch][0] + 2, "R1 descriptor length", 64'(len), 64'(el[ch][0] + 2));
                    void'(el[ch].pop_front());
                    cur_ch = ch;
                    if (order_on && order_q.size() > 0) begin
                        chk(ch == order_q[0], "R2 round-robin grant order", 64'(ch), 64'(order_q[0]));
                        void'(order_q.pop_front());
                    end
                end
                if (cur_left <= 0) cur_ch = -1;
            end else begin
                if (!junk) begin
                    if (eq[cur_ch].size() == 0) chk(1'b0, "R3 extra word in packet", 64'(ext_word), 0);
                    else begin
                        chk(ext_word == eq[cur_ch][0], "R3 packet word contiguous and ordered",
                            64'(ext_word), 64'(eq[cur_ch][0]));
                        void'(eq[cur_ch].pop_front());
                    end
                end
                cur_left--;
                if (cur_left == 0) cur_ch = -1;
            end
        end
    end

    task automatic push_pkt(input int c, input int ns, input bit send, input int now_n, output int id);
        logic [DW-1:0] h;
        id = seq;
        seq++;
        h = {8'hA5, 8'(c), 16'(id)};
        hq_d[c].push_back(h);
        hq_l[c].push_back(ns);
        if (send) begin
            el[c].push_back(ns);
            eq[c].push_back(h);
        end
        for (int k = 0; k < ns; k++) begin
            if (k < now_n) sq[c].push_back(smp_val(c, id, k));
            if (send) eq[c].push_back(smp_val(c, id, k));
        end
    endtask

    task automatic push_rest(input int c, input int id, input int from, input int ns);
        for (int k = from; k < ns; k++) sq[c].push_back(smp_val(c, id, k));
    endtask

    task automatic wait_idle();
        bit busy;
        do begin
            @(negedge clk);
            busy = 1'b0;
            for (int c = 0; c < N; c++) if (hq_d[c].size() > 0 || sq[c].size() > 0) busy = 1'b1;
        end while (busy);
        repeat (60) @(negedge clk);
    endtask

    task automatic check_all_sent(input string req);
        int left;
        left = 0;
        for (int c = 0; c < N; c++) left += el[c].size() + eq[c].size();
        chk(left == 0, req, 64'(left), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        int id;
        drop_clr = 1'b0;
        ext_free = 16'd200;
        repeat (4) @(negedge clk);
        chk(hp == '0 && sp == '0, "R10 no pops in reset", 64'({hp, sp}), 0);
        chk(ext_wr == 1'b0, "R10 no external write in reset", 64'(ext_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drop_count == 0, "R10 drop counter zero after reset", 64'(drop_count), 0);

        // R2: all channels loaded at once, two packets each, incl. a zero-sample one (R1)
        order_on = 1'b1;
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < N; c++) begin
                push_pkt(c, (r == 1 && c == 3) ? 0 : (c % 4) + 1 + r, 1'b1, 99, id);
                order_q.push_back(c);
            end
        end
        wait_idle();
        check_all_sent("R6 all packets delivered with ample space");
        chk(order_q.size() == 0, "R2 every grant observed", 64'(order_q.size()), 0);
        chk(drop_count == 0, "R7 no drops with ample space", 64'(drop_count), 0);

        // R4: channel 2 stalls mid-packet, channel 5 must wait behind it
        order_q.push_back(2);
        order_q.push_back(5);
        begin
            int id2;
            push_pkt(2, 4, 1'b1, 1, id2);
            push_pkt(5, 3, 1'b1, 3, id);
            repeat (30) @(negedge clk);
            chk(sp == '0, "R4 no sample pop while stalled", 64'(sp), 0);
            chk(hq_d[5].size() == 1, "R3 waiting channel keeps its header", 64'(hq_d[5].size()), 1);
            push_rest(2, id2, 1, 4);
        end
        wait_idle();
        check_all_sent("R4 stalled packet completes without loss");
        chk(order_q.size() == 0, "R2 stall order observed", 64'(order_q.size()), 0);
        order_on = 1'b0;

        // R6: exact-fit boundary
        ext_free = 16'd5;
        push_pkt(7, 3, 1'b1, 99, id);
        wait_idle();
        check_all_sent("R6 packet equal to free space is sent");
        chk(drop_count == 0, "R6 exact fit not dropped", 64'(drop_count), 0);
        ext_free = 16'd4;
        push_pkt(7, 3, 1'b0, 99, id);
        wait_idle();
        chk(drop_count == 1, "R7 one-word-short packet dropped", 64'(drop_count), 1);
        ext_free = 16'd2;
        push_pkt(4, 0, 1'b1, 99, id);
        wait_idle();
        check_all_sent("R6 two-word packet fits in two words");
        chk(drop_count == 1, "R7 count unchanged when sent", 64'(drop_count), 1);

        // R7/R8: no space at all
        ext_free = 16'd0;
        for (int c = 0; c < N; c++) push_pkt(c, c % 3, 1'b0, 99, id);
        wait_idle();
        chk(drop_count == 11, "R7 every refused packet counted", 64'(drop_count), 11);
        chk(dc2 == 2'b11, "R8 narrow counter saturates", 64'(dc2), 3);

        // R9: clear
        drop_clr = 1'b1;
        @(negedge clk);
        drop_clr = 1'b0;
        chk(drop_count == 0, "R9 clear zeroes counter", 64'(drop_count), 0);
        chk(dc2 == 2'b00, "R9 clear zeroes saturated counter", 64'(dc2), 0);
        push_pkt(1, 2, 1'b0, 99, id);
        wait_idle();
        chk(drop_count == 1, "R7 counting resumes after clear", 64'(drop_count), 1);

        summary();
        $finish;
    end
endmodule